// File: doc/BRIEF.md
# Bidirectional Line Direction Arbiter

This block joins a card-side data line and a host-side data line. Both lines idle high and are pulled low only through pull-down enables, so either side may start a transfer. Whichever line falls first becomes the input. The block then pulls the other line low for as long as the input stays low. When the input line rises again, both lines return to an undriven, high idle state, and the next falling edge decides the direction afresh.

Arbitration runs only while the enable bit is set and the power sequencer has opened reception. Until the sequencer opens reception, the card line is held low. The host line is left high from reset onward. Copying the level across is asymmetric. A falling level reaches the other side after a longer delay (`FALL_CYC` clock cycles). A rising level is released after a shorter one (`RISE_CYC` cycles), which keeps the line model close to the real pad timing. Both line inputs are synchronized with `SYNC_STAGES` flops before any edge is detected.

Top module: `line_dir_arbiter`

## Requirements
- R1: During and after reset with `rxEnable` low, `cardPullDown` is 1, `hostPullDown` is 0 and `dirValid` is 0.
- R2: With the block armed and idle, a falling edge on the card line sets `dirValid`=1 and `fromCard`=1 three cycles after the input changes. `hostPullDown` rises `FALL_CYC`+3 cycles after the input change.
- R3: With the block armed and idle, a falling edge on the host line sets `dirValid`=1 and `fromCard`=0 three cycles after the input change. `cardPullDown` rises `FALL_CYC`+3 cycles after the input change.
- R4: A rising edge on the current input line clears `dirValid` three cycles after the change. The output-side pull-down is released `RISE_CYC`+3 cycles after the change.
- R5: Falling edges on the output line, including those the block causes itself, are ignored. The direction never flips while a transfer is active, and no new transfer starts when the driven line is released.
- R6: When both lines fall in the same cycle, the card line wins (`fromCard`=1, `hostPullDown` asserted, `cardPullDown` not asserted).
- R7: While `arbEnable` is 0, no falling edge starts a transfer. Dropping `arbEnable` during a transfer clears `dirValid` on the next clock edge and releases the output pull-down `RISE_CYC`+1 cycles after the drop.
- R8: While `rxEnable` is 0, `cardPullDown` is 1 and no transfer starts.
- R9: An input low pulse that ends before the fall delay has elapsed never asserts the other line's pull-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| arbEnable | input | 1 | Arbitration enable bit |
| rxEnable | input | 1 | Reception open, from the power sequencer |
| cardLineIn | input | 1 | Sampled level of the card-side line (asynchronous) |
| hostLineIn | input | 1 | Sampled level of the host-side line (asynchronous) |
| cardPullDown | output | 1 | Pull-down enable for the card-side line |
| hostPullDown | output | 1 | Pull-down enable for the host-side line |
| dirValid | output | 1 | A transfer direction is currently held |
| fromCard | output | 1 | 1: card line is the input; 0: host line is the input |

## Verification
The bench models each line as a wired AND of an external driver and the block's pull-down, so the block sees its own drive coming back. It tries a card-first fall, a host-first fall, a simultaneous fall and a pulse shorter than the fall delay. These patterns separate the priority rule, the per-direction delay shaping and the suppression of self-caused edges. Runs with `arbEnable` or `rxEnable` low, and a mid-transfer drop of `arbEnable`, show the gating is present and that an aborted transfer releases cleanly. Every latency is measured in exact cycles, so a change in the synchronizer depth or in either delay shows up.

// File: rtl/line_dir_pkg.sv
package line_dir_pkg;

  typedef enum logic [1:0] {
    ARB_IDLE    = 2'd0,
    ARB_CARD_IN = 2'd1,
    ARB_HOST_IN = 2'd2
  } arbState_e;

  // edge events seen on the synchronized lines
  typedef struct packed {
    logic cardFall;
    logic cardRise;
    logic hostFall;
    logic hostRise;
  } lineEvt_t;

  // requests from control to the datapath
  typedef struct packed {
    logic pullCard;
    logic pullHost;
  } arbCmd_t;

endpackage

// File: rtl/line_dir_shaper.sv
// Delays a pull-down request: asserting waits FALL_CYC stable cycles,
// releasing waits RISE_CYC stable cycles.
module line_dir_shaper #(
  parameter int FALL_CYC = 20,
  parameter int RISE_CYC = 5
) (
  input  logic clk,
  input  logic rstN,
  input  logic req,
  output logic pull
);
  localparam int MAX_CYC = (FALL_CYC > RISE_CYC) ? FALL_CYC : RISE_CYC;
  localparam int CW      = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] limM1;

  always_comb limM1 = req ? CW'(FALL_CYC - 1) : CW'(RISE_CYC - 1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pull <= 1'b0;
      cnt  <= '0;
    end else if (req == pull) begin
      cnt <= '0;
    end else if (cnt == limM1) begin
      pull <= req;
      cnt  <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/line_dir_datapath.sv
module line_dir_datapath
  import line_dir_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FALL_CYC    = 20,
  parameter int RISE_CYC    = 5
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     cardLineIn,
  input  logic     hostLineIn,
  input  logic     rxEnable,
  input  arbCmd_t  cmd,
  output lineEvt_t evt,
  output logic     cardPullDown,
  output logic     hostPullDown
);
  localparam int NUM_LINES = 2;  // index 0 = card, 1 = host

  logic [NUM_LINES-1:0] rawVec, fallVec, riseVec, reqVec, pullVec;

  assign rawVec = {hostLineIn, cardLineIn};
  assign reqVec = {cmd.pullHost, cmd.pullCard};

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    logic [SYNC_STAGES-1:0] syncQ;
    logic prevQ;
    logic nowLvl;

    assign nowLvl = syncQ[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncQ <= '1;
        prevQ <= 1'b1;
      end else begin
        syncQ <= {syncQ[SYNC_STAGES-2:0], rawVec[i]};
        prevQ <= nowLvl;
      end
    end

    assign fallVec[i] = prevQ & ~nowLvl;
    assign riseVec[i] = ~prevQ & nowLvl;

    line_dir_shaper #(
      .FALL_CYC(FALL_CYC),
      .RISE_CYC(RISE_CYC)
    ) u_shaper (
      .clk (clk),
      .rstN(rstN),
      .req (reqVec[i]),
      .pull(pullVec[i])
    );
  end

  always_comb begin
    evt.cardFall = fallVec[0];
    evt.cardRise = riseVec[0];
    evt.hostFall = fallVec[1];
    evt.hostRise = riseVec[1];
  end

  // card line stays low until the sequencer opens reception
  assign cardPullDown = ~rxEnable | pullVec[0];
  assign hostPullDown = pullVec[1];
endmodule

// File: rtl/line_dir_control.sv
module line_dir_control
  import line_dir_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     arbEnable,
  input  logic     rxEnable,
  input  lineEvt_t evt,
  output arbCmd_t  cmd,
  output logic     dirValid,
  output logic     fromCard
);
  arbState_e state, nxt;
  logic armed;

  assign armed = arbEnable & rxEnable;

  always_comb begin
    nxt = state;
    unique case (state)
      ARB_IDLE: begin
        if (armed) begin
          if (evt.cardFall)      nxt = ARB_CARD_IN;  // card wins ties
          else if (evt.hostFall) nxt = ARB_HOST_IN;
        end
      end
      ARB_CARD_IN: if (!armed || evt.cardRise) nxt = ARB_IDLE;
      ARB_HOST_IN: if (!armed || evt.hostRise) nxt = ARB_IDLE;
      default:     nxt = ARB_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ARB_IDLE;
    else       state <= nxt;
  end

  always_comb begin
    cmd.pullHost = (state == ARB_CARD_IN);
    cmd.pullCard = (state == ARB_HOST_IN);
  end

  assign dirValid = (state != ARB_IDLE);
  assign fromCard = (state == ARB_CARD_IN);
endmodule

// File: rtl/line_dir_arbiter.sv
module line_dir_arbiter
  import line_dir_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FALL_CYC    = 20,
  parameter int RISE_CYC    = 5
) (
  input  logic clk,
  input  logic rstN,
  input  logic arbEnable,
  input  logic rxEnable,
  input  logic cardLineIn,
  input  logic hostLineIn,
  output logic cardPullDown,
  output logic hostPullDown,
  output logic dirValid,
  output logic fromCard
);
  lineEvt_t evt;
  arbCmd_t  cmd;

  line_dir_control u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .arbEnable(arbEnable),
    .rxEnable (rxEnable),
    .evt      (evt),
    .cmd      (cmd),
    .dirValid (dirValid),
    .fromCard (fromCard)
  );

  line_dir_datapath #(
    .SYNC_STAGES(SYNC_STAGES),
    .FALL_CYC   (FALL_CYC),
    .RISE_CYC   (RISE_CYC)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .cardLineIn  (cardLineIn),
    .hostLineIn  (hostLineIn),
    .rxEnable    (rxEnable),
    .cmd         (cmd),
    .evt         (evt),
    .cardPullDown(cardPullDown),
    .hostPullDown(hostPullDown)
  );
endmodule

// File: rtl/line_dir_arbiter_chk.sv
module line_dir_arbiter_chk (
  input logic clk,
  input logic rstN,
  input logic arbEnable,
  input logic rxEnable,
  input logic cardPullDown,
  input logic hostPullDown,
  input logic dirValid,
  input logic fromCard
);
  // R2
  host_pull_from_card_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hostPullDown) |-> $past(dirValid && fromCard));

  // R3
  card_pull_from_host_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(cardPullDown) && rxEnable && $past(rxEnable)) |-> $past(dirValid && !fromCard));

  // R5
  no_dir_flip_chk: assert property (@(posedge clk) disable iff (!rstN)
    dirValid |=> (!dirValid || (fromCard == $past(fromCard))));

  // R7
  arb_off_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !arbEnable |=> !dirValid);

  // R8
  rx_off_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rxEnable |=> !dirValid);
endmodule

bind line_dir_arbiter line_dir_arbiter_chk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .arbEnable   (arbEnable),
  .rxEnable    (rxEnable),
  .cardPullDown(cardPullDown),
  .hostPullDown(hostPullDown),
  .dirValid    (dirValid),
  .fromCard    (fromCard)
);

// File: tb/line_dir_arbiter_bench.sv
`timescale 1ns/1ps
module line_dir_arbiter_bench;
  localparam int FALL_CYC = 20;
  localparam int RISE_CYC = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic arbEnable = 1'b0;
  logic rxEnable = 1'b0;
  logic cardExt = 1'b1;
  logic hostExt = 1'b1;
  logic cardPullDown, hostPullDown, dirValid, fromCard;
  logic cardLine, hostLine;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  // wired-AND line model
  assign cardLine = cardExt & ~cardPullDown;
  assign hostLine = hostExt & ~hostPullDown;

  line_dir_arbiter #(.SYNC_STAGES(2), .FALL_CYC(FALL_CYC), .RISE_CYC(RISE_CYC)) u_line_dir_arbiter (
    .clk(clk), .rstN(rstN), .arbEnable(arbEnable), .rxEnable(rxEnable),
    .cardLineIn(cardLine), .hostLineIn(hostLine),
    .cardPullDown(cardPullDown), .hostPullDown(hostPullDown),
    .dirValid(dirValid), .fromCard(fromCard)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // first cycle (negedge count) at which each output leaves its start value, -1 if never
  task automatic watch(input int cyc, output int tv, output int th, output int tc);
    logic v0, h0, c0;
    v0 = dirValid; h0 = hostPullDown; c0 = cardPullDown;
    tv = -1; th = -1; tc = -1;
    for (int n = 1; n <= cyc; n++) begin
      @(negedge clk);
      if (tv < 0 && dirValid !== v0) tv = n;
      if (th < 0 && hostPullDown !== h0) th = n;
      if (tc < 0 && cardPullDown !== c0) tc = n;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1", "cardPullDown in reset", int'(cardPullDown), 1);
    chk("R1", "hostPullDown in reset", int'(hostPullDown), 0);
    @(negedge clk); rstN = 1'b1;
    idle(3);
    chk("R1", "cardPullDown after reset", int'(cardPullDown), 1);
    chk("R1", "hostPullDown after reset", int'(hostPullDown), 0);
    chk("R1", "dirValid after reset", int'(dirValid), 0);
    rxEnable = 1'b1; arbEnable = 1'b1;
    idle(10);
    chk("R8", "cardPullDown once reception open", int'(cardPullDown), 0);
  endtask

  task automatic t_card_first();
    int tv, th, tc;
    cardExt = 1'b0;
    watch(40, tv, th, tc);
    chk("R2", "dirValid latency", tv, 3);
    chk("R2", "hostPullDown latency", th, FALL_CYC + 3);
    chk("R2", "cardPullDown untouched", tc, -1);
    chk("R2", "fromCard", int'(fromCard), 1);
    watch(10, tv, th, tc);
    chk("R5", "hold while host line low", tv, -1);
    chk("R5", "direction kept", int'(fromCard), 1);
    cardExt = 1'b1;
    watch(20, tv, th, tc);
    chk("R4", "dirValid clear latency", tv, 3);
    chk("R4", "hostPullDown release latency", th, RISE_CYC + 3);
    watch(30, tv, th, tc);
    chk("R5", "no relock after release dirValid", tv, -1);
    chk("R5", "no relock after release cardPullDown", tc, -1);
  endtask

  task automatic t_host_first();
    int tv, th, tc;
    hostExt = 1'b0;
    watch(40, tv, th, tc);
    chk("R3", "dirValid latency", tv, 3);
    chk("R3", "cardPullDown latency", tc, FALL_CYC + 3);
    chk("R3", "hostPullDown untouched", th, -1);
    chk("R3", "fromCard", int'(fromCard), 0);
    hostExt = 1'b1;
    watch(20, tv, th, tc);
    chk("R4", "dirValid clear latency host", tv, 3);
    chk("R4", "cardPullDown release latency", tc, RISE_CYC + 3);
    watch(30, tv, th, tc);
    chk("R5", "no relock after host transfer", tv, -1);
  endtask

  task automatic t_simultaneous();
    int tv, th, tc;
    cardExt = 1'b0; hostExt = 1'b0;
    watch(40, tv, th, tc);
    chk("R6", "fromCard on tie", int'(fromCard), 1);
    chk("R6", "hostPullDown on tie", th, FALL_CYC + 3);
    chk("R6", "cardPullDown on tie", tc, -1);
    cardExt = 1'b1; hostExt = 1'b1;
    watch(20, tv, th, tc);
    chk("R6", "release after tie", th, RISE_CYC + 3);
    idle(20);
  endtask

  task automatic t_short_pulse();
    int tv, th, tc;
    cardExt = 1'b0;
    idle(FALL_CYC / 2);
    cardExt = 1'b1;
    watch(40, tv, th, tc);
    chk("R9", "short pulse hostPullDown", th, -1);
    chk("R9", "short pulse dirValid idle", int'(dirValid), 0);
    chk("R9", "short pulse hostPullDown level", int'(hostPullDown), 0);
  endtask

  task automatic t_arb_disable();
    int tv, th, tc;
    arbEnable = 1'b0;
    hostExt = 1'b0;
    watch(40, tv, th, tc);
    chk("R7", "disabled dirValid", tv, -1);
    chk("R7", "disabled cardPullDown", tc, -1);
    hostExt = 1'b1;
    idle(10);
    arbEnable = 1'b1;
    idle(5);
    cardExt = 1'b0;
    idle(30);
    chk("R7", "transfer active before abort", int'(hostPullDown), 1);
    arbEnable = 1'b0;
    watch(20, tv, th, tc);
    chk("R7", "abort dirValid latency", tv, 1);
    chk("R7", "abort hostPullDown release", th, RISE_CYC + 1);
    cardExt = 1'b1;
    idle(10);
    arbEnable = 1'b1;
    idle(10);
  endtask

  task automatic t_rx_disable();
    int tv, th, tc;
    rxEnable = 1'b0;
    #1;
    chk("R8", "cardPullDown with reception closed", int'(cardPullDown), 1);
    @(negedge clk);
    hostExt = 1'b0;
    watch(40, tv, th, tc);
    chk("R8", "no transfer while closed", tv, -1);
    chk("R8", "cardPullDown stays", int'(cardPullDown), 1);
    hostExt = 1'b1;
    idle(10);
    rxEnable = 1'b1;
    idle(10);
    chk("R8", "cardPullDown released on reopen", int'(cardPullDown), 0);
    chk("R8", "idle after reopen", int'(dirValid), 0);
  endtask

  initial begin
    #1;
    t_reset();
    t_card_first();
    t_host_first();
    t_simultaneous();
    t_short_pulse();
    t_arb_disable();
    t_rx_disable();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule